// File: doc/BRIEF.md
# Embedded Operation Status Poller

This block produces what a host sees on the data bus while a flash-style array runs an internally timed word program or block erase. When a program or erase is launched, the block raises `busy` and starts a cycle-count timer. Until the timer expires, every read returns a status word instead of pure array data:

- The polling bit reports the inverse of that bit of the word being programmed, or zero while an erase runs.
- The toggle bit inverts once per read access.

When the timer expires, reads go back to returning the array word unchanged. In the same cycle the block emits one write-back word that the surrounding array model stores:

- For a program, it is the old contents ANDed with the new data, because programming can only clear bits.
- For an erase, it is all ones.

Command decoding, addressing and the array storage itself sit outside the block. The host presents a start pulse with its data, and the array supplies its current word on `arr_data`. Starts that arrive while an operation is running are dropped. An active-low reset aborts a running operation without a write-back and keeps the output driver off for as long as it is held low.

Top module: `embop_status_poller`

## Requirements
- R1: An accepted start raises `busy` at the next clock edge. `busy` then stays high for exactly PROG_CYCLES clock cycles for a program and exactly ERASE_CYCLES cycles for an erase (defaults 12 and 20).
- R2: While a program is busy, read data bit 7 (POLL_BIT) equals the inverse of bit 7 of the word being programmed.
- R3: While an erase is busy, read data bit 7 is 0.
- R4: The toggle flag on bit 6 (TOGGLE_BIT) is cleared at each accepted start. During busy it inverts at the first clock edge of every read access (rising `rd_req`), so the first read of an operation shows 1 and the next shows 0. It never changes while idle.
- R5: During busy, with the default MASK_OTHER_BITS=0, all bits other than 7 and 6 carry `arr_data`.
- R6: When not busy, `rd_data` equals `arr_data` on every bit.
- R7: `prog_start` or `erase_start` asserted while `busy` is high is ignored. It does not change the busy length, the polled bit 7 or the toggle sequence, and it produces no extra write-back.
- R8: Low `rst_n` clears `busy` at once, aborts the running operation with no write-back, and returns the block to idle reads once released.
- R9: In the cycle after an operation completes, `wb_valid` is high for exactly one cycle. `wb_data` is `arr_data & prog_data` (both sampled at the start) for a program, and all ones for an erase.
- R10: If `prog_start` and `erase_start` are both high at an accepted start, the erase is performed.
- R11: `rd_drive` is high exactly when `rd_req` is high and `rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; aborts any operation |
| prog_start | input | 1 | Launch a word program (one-cycle pulse) |
| prog_data | input | DW | Word to be programmed, sampled with `prog_start` |
| erase_start | input | 1 | Launch a block or chip erase (one-cycle pulse) |
| rd_req | input | 1 | Read access in progress (level; rising edge marks a new access) |
| arr_data | input | DW | Current array word at the read and program location |
| rd_data | output | DW | Read data: status word while busy, array word otherwise |
| rd_drive | output | 1 | Output driver enable; low means the bus floats |
| busy | output | 1 | An embedded operation is running |
| wb_valid | output | 1 | One-cycle pulse carrying the completed operation's result |
| wb_data | output | DW | Word to store into the array when `wb_valid` is high |

## Verification
On every cycle, the embedded assertions check three things:

- The polled bit 7 matches the operation kind.
- Idle reads are transparent.
- Starts during busy leave the captured operation untouched, the toggle flag stays frozen while idle, `busy` can only fall together with a completion pulse, and completion pulses never repeat back to back.

Other properties can only be shown by the bench's scenarios:

- The exact busy length for each kind.
- The alternating toggle sequence across successive reads.
- The AND-merged and all-ones write-back values.
- Erase priority on simultaneous starts.
- Loss of the write-back when reset cuts an operation short.

// File: rtl/embop_pkg.sv
package embop_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ERASE = 2'd2
   } embop_kind_e;

endpackage

// File: rtl/embop_timer.sv
module embop_timer
   import embop_pkg::*;
#(
   parameter int PROG_CYCLES  = 12,
   parameter int ERASE_CYCLES = 20
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  embop_kind_e kind,
   output logic        busy,
   output logic        done
);

   localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_len
      $error("embop_timer: durations must be at least one cycle");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            busy <= 1'b1;
            cnt  <= (kind == OP_ERASE) ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
         end else if (busy) begin
            if (cnt == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   assert_load_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);

   assert_fall_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

// File: rtl/embop_toggle.sv
module embop_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic busy,
   input  logic rd_req,
   output logic tgl
);

   logic rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         tgl  <= 1'b0;
      end else begin
         rd_q <= rd_req;
         if (clr)
            tgl <= 1'b0;
         else if (busy && rd_req && !rd_q)
            tgl <= ~tgl;
      end
   end

   assert_tgl_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !clr) |=> $stable(tgl));

endmodule

// File: rtl/embop_status_poller.sv
module embop_status_poller
   import embop_pkg::*;
#(
   parameter int DW              = 16,
   parameter int PROG_CYCLES     = 12,
   parameter int ERASE_CYCLES    = 20,
   parameter int POLL_BIT        = 7,
   parameter int TOGGLE_BIT      = 6,
   parameter bit MASK_OTHER_BITS = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prog_start,
   input  logic [DW-1:0] prog_data,
   input  logic          erase_start,
   input  logic          rd_req,
   input  logic [DW-1:0] arr_data,
   output logic [DW-1:0] rd_data,
   output logic          rd_drive,
   output logic          busy,
   output logic          wb_valid,
   output logic [DW-1:0] wb_data
);

   localparam logic [DW-1:0] ALL_ONES = '1;

   if (DW < 2) begin : g_bad_dw
      $error("embop_status_poller: DW too small");
   end
   if (POLL_BIT >= DW || TOGGLE_BIT >= DW || POLL_BIT == TOGGLE_BIT) begin : g_bad_bits
      $error("embop_status_poller: status bit positions invalid");
   end

   logic          accept;
   embop_kind_e   kind_sel;
   embop_kind_e   op_q;
   logic          poll_q;
   logic [DW-1:0] wb_q;
   logic          tgl;
   logic [DW-1:0] base;
   logic [DW-1:0] status;

   assign accept   = (prog_start || erase_start) && !busy;
   assign kind_sel = erase_start ? OP_ERASE : OP_PROG;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_NONE;
         poll_q <= 1'b0;
         wb_q   <= ALL_ONES;
      end else if (accept) begin
         op_q   <= kind_sel;
         poll_q <= ~prog_data[POLL_BIT];
         wb_q   <= erase_start ? ALL_ONES : (arr_data & prog_data);
      end
   end

   embop_timer #(
      .PROG_CYCLES  (PROG_CYCLES),
      .ERASE_CYCLES (ERASE_CYCLES)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .kind  (kind_sel),
      .busy  (busy),
      .done  (wb_valid)
   );

   embop_toggle u_toggle (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .busy   (busy),
      .rd_req (rd_req),
      .tgl    (tgl)
   );

   if (MASK_OTHER_BITS) begin : g_mask
      assign base = '0;
   end else begin : g_pass
      assign base = arr_data;
   end

   always_comb begin
      status             = base;
      status[POLL_BIT]   = (op_q == OP_ERASE) ? 1'b0 : poll_q;
      status[TOGGLE_BIT] = tgl;
   end

   assign rd_data  = busy ? status : arr_data;
   assign rd_drive = rst_n && rd_req;
   assign wb_data  = wb_q;

   assert_poll_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q == OP_PROG) |-> (rd_data[POLL_BIT] == poll_q));

   assert_poll_erase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q == OP_ERASE) |-> (rd_data[POLL_BIT] == 1'b0));

   assert_idle_true_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (rd_data == arr_data));

   assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (prog_start || erase_start)) |=> ($stable(op_q) && $stable(poll_q) && $stable(wb_q)));

   assert_wb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !wb_valid);

endmodule

// File: tb/embop_status_poller_tb.sv
module embop_status_poller_tb;

   localparam int DW = 16;
   localparam int PC = 12;
   localparam int EC = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          prog_start = 1'b0;
   logic [DW-1:0] prog_data = '0;
   logic          erase_start = 1'b0;
   logic          rd_req = 1'b0;
   logic [DW-1:0] arr_data = '0;
   logic [DW-1:0] rd_data;
   logic          rd_drive;
   logic          busy;
   logic          wb_valid;
   logic [DW-1:0] wb_data;

   int total = 0;
   int bad = 0;
   int busy_run = 0;
   int last_len = 0;
   logic [DW-1:0] exp_q[$];

   always #2 clk = ~clk;

   embop_status_poller #(
      .DW           (DW),
      .PROG_CYCLES  (PC),
      .ERASE_CYCLES (EC)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .prog_start  (prog_start),
      .prog_data   (prog_data),
      .erase_start (erase_start),
      .rd_req      (rd_req),
      .arr_data    (arr_data),
      .rd_data     (rd_data),
      .rd_drive    (rd_drive),
      .busy        (busy),
      .wb_valid    (wb_valid),
      .wb_data     (wb_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // monitor: busy length tracking and write-back scoreboard
   always @(negedge clk) begin
      if (busy) busy_run++;
      else if (busy_run != 0) begin
         last_len = busy_run;
         busy_run = 0;
      end
      if (wb_valid && rst_n) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected write-back", 32'(wb_data), 32'hX);
         end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk(wb_data == e, "R9 write-back word", 32'(wb_data), 32'(e));
         end
      end
   end

   initial begin
      #(4 * 100000);
      chk(1'b0, "watchdog expired", 0, 0);
      finish_run();
   end

   function automatic logic [DW-1:0] busy_word(input logic [DW-1:0] a, input logic b7, input logic b6);
      logic [DW-1:0] w;
      w = a;
      w[7] = b7;
      w[6] = b6;
      return w;
   endfunction

   task automatic do_read(output logic [DW-1:0] v);
      @(negedge clk) rd_req = 1'b1;
      @(negedge clk);
      v = rd_data;
      chk(rd_drive == 1'b1, "R11 driver on during read", 32'(rd_drive), 1);
      rd_req = 1'b0;
   endtask

   task automatic start_op(input bit prg, input bit ers, input logic [DW-1:0] d, input logic [DW-1:0] old);
      @(negedge clk);
      arr_data = old;
      prog_data = d;
      prog_start = prg;
      erase_start = ers;
      @(negedge clk);
      prog_start = 1'b0;
      erase_start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      logic [DW-1:0] v;

      // reset state
      rd_req = 1'b1;
      #7;
      chk(busy == 1'b0, "R8 busy low in reset", 32'(busy), 0);
      chk(wb_valid == 1'b0, "R9 no write-back in reset", 32'(wb_valid), 0);
      chk(rd_drive == 1'b0, "R11 driver off in reset", 32'(rd_drive), 0);
      @(negedge clk) rst_n = 1'b1; rd_req = 1'b0;
      @(negedge clk);
      chk(rd_drive == 1'b0, "R11 driver off without read", 32'(rd_drive), 0);

      // idle read
      arr_data = 16'hA5C3;
      do_read(v);
      chk(v == 16'hA5C3, "R6 idle read true data", 32'(v), 32'hA5C3);
      do_read(v);
      chk(v == 16'hA5C3, "R6 idle bit6 steady", 32'(v), 32'hA5C3);

      // program with bit7 = 1
      start_op(1'b1, 1'b0, 16'h0F80, 16'hFFFF);
      exp_q.push_back(16'h0F80);
      chk(busy == 1'b1, "R1 busy after start", 32'(busy), 1);
      arr_data = 16'h3C3C;
      do_read(v);
      chk(v == busy_word(16'h3C3C, 1'b0, 1'b1), "R2 R5 R4 first poll", 32'(v), 32'(busy_word(16'h3C3C, 1'b0, 1'b1)));
      do_read(v);
      chk(v[6] == 1'b0, "R4 second poll toggles", 32'(v[6]), 0);
      do_read(v);
      chk(v[6] == 1'b1, "R4 third poll toggles", 32'(v[6]), 1);
      wait_idle();
      chk(last_len == PC, "R1 program busy length", 32'(last_len), PC);
      do_read(v);
      chk(v == 16'h3C3C, "R6 true data after program", 32'(v), 32'h3C3C);

      // program with bit7 = 0, AND merge
      start_op(1'b1, 1'b0, 16'h1234, 16'hF0F0);
      exp_q.push_back(16'h1030);
      do_read(v);
      chk(v == busy_word(16'hF0F0, 1'b1, 1'b1), "R2 R4 poll restarts", 32'(v), 32'(busy_word(16'hF0F0, 1'b1, 1'b1)));
      wait_idle();

      // erase
      start_op(1'b0, 1'b1, 16'h0000, 16'h00FF);
      exp_q.push_back(16'hFFFF);
      do_read(v);
      chk(v == busy_word(16'h00FF, 1'b0, 1'b1), "R3 erase poll", 32'(v), 32'(busy_word(16'h00FF, 1'b0, 1'b1)));
      do_read(v);
      chk(v[6] == 1'b0, "R4 erase toggle", 32'(v[6]), 0);
      wait_idle();
      chk(last_len == EC, "R1 erase busy length", 32'(last_len), EC);

      // starts while busy are ignored
      start_op(1'b1, 1'b0, 16'h0001, 16'hFFFF);
      exp_q.push_back(16'h0001);
      do_read(v);
      chk(v[7] == 1'b1, "R7 poll before ignored start", 32'(v[7]), 1);
      @(negedge clk) erase_start = 1'b1;
      @(negedge clk) erase_start = 1'b0; prog_start = 1'b1; prog_data = 16'h0080;
      @(negedge clk) prog_start = 1'b0;
      do_read(v);
      chk(v[7] == 1'b1, "R7 poll unchanged after ignored starts", 32'(v[7]), 1);
      chk(v[6] == 1'b0, "R7 toggle sequence unchanged", 32'(v[6]), 0);
      wait_idle();
      chk(last_len == PC, "R7 busy length unchanged", 32'(last_len), PC);

      // simultaneous starts: erase wins
      start_op(1'b1, 1'b1, 16'h0000, 16'h1111);
      exp_q.push_back(16'hFFFF);
      do_read(v);
      chk(v[7] == 1'b0, "R10 erase priority poll", 32'(v[7]), 0);
      wait_idle();
      chk(last_len == EC, "R10 erase priority length", 32'(last_len), EC);

      // reset aborts
      start_op(1'b1, 1'b0, 16'h0000, 16'hFFFF);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      rd_req = 1'b1;
      #1;
      chk(busy == 1'b0, "R8 abort clears busy", 32'(busy), 0);
      chk(rd_drive == 1'b0, "R8 R11 float in reset", 32'(rd_drive), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd_req = 1'b0;
      repeat (PC + 4) @(negedge clk);
      chk(busy == 1'b0, "R8 stays idle after abort", 32'(busy), 0);
      arr_data = 16'h5A5A;
      do_read(v);
      chk(v == 16'h5A5A, "R8 read mode after reset", 32'(v), 32'h5A5A);

      chk(exp_q.size() == 0, "R9 all write-backs seen", 32'(exp_q.size()), 0);
      finish_run();
   end

endmodule